// File: doc/BRIEF.md
# Hexadecimal Keypad Matrix Scanner

This block scans a sixteen-key switch matrix laid out as four rows and four columns and turns a press into a 4-bit hexadecimal key value. The four row lines are active-low outputs, and the four column lines are inputs held high by pull-ups. While nothing is happening, every row is held low. Any press therefore drags at least one column low, and the block raises a one-cycle press interrupt.

The block then walks a single low row through the matrix in a fixed order and reads the columns on each row. The first row that shows a low column fixes the row and column pattern, and a lookup turns that pattern into the key value. The same row stays driven for a debounce interval. The columns are read again, and the key is accepted only when the second reading matches the first. An accepted key is shown on the key output with a one-cycle valid strobe. The block then holds all rows low again and waits until every column is back high before it watches for the next press.

The column inputs pass through a synchroniser before any logic uses them. Only one key at a time is reported. When several keys show in one row, the key on the highest column bit wins.

Top module: `keypad_scanner`

## Requirements
- R1: While reset is high, and in the cycle after reset is released, row_out is 0000, key_valid is 0, press_irq is 0 and key_code is 0.
- R2: In idle all rows are driven low (row_out = 0000). A column that goes low while idle produces exactly one press_irq pulse, three clock edges later: two synchroniser stages plus the output register.
- R3: The scan drives row_out = 0111, 1011, 1101, 1110 in that order, one pattern at a time. Each pattern is held for SETTLE_CYCLES cycles, and the columns are sampled in the last of those cycles. Every row_out value is either 0000 or has exactly one bit low.
- R4: Rows are numbered 0 to 3 by the position of their low bit: bit 3 is row 0 and bit 0 is row 1110, row 3. Columns are taken from bit 3 down to bit 0. Row 0 holds keys 1,2,3,0. Row 1 holds 4,5,6,F. Row 2 holds 7,8,9,E. Row 3 holds A,B,C,D. For example, row_out 1101 with columns 1011 is key 8.
- R5: If more than one column is low in the selected row, the key on the highest column bit is reported. Because rows are scanned in order, a key in an earlier row takes precedence over a key in a later row.
- R6: Once a key is found, its row stays driven for DEBOUNCE_CYCLES cycles and the columns are re-read. A key_valid pulse is produced only if the re-read column pattern equals the first one; otherwise nothing is reported.
- R7: key_valid is a single-cycle pulse, and key_code carries the key value in that cycle. key_code holds its value until the next accepted key.
- R8: After the debounce re-read, row_out returns to 0000. The block does not rescan, report or interrupt again until the synchronised columns have all returned high. A key held down is therefore reported only once.
- R9: If no column is low on any of the four rows (the key was released during the scan), the scan ends with row_out = 0000 and no key_valid pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| col_in | input | 4 | Column lines from the matrix, pulled high, low when a key in a driven row is closed |
| row_out | output | 4 | Active-low row drive to the matrix |
| key_code | output | 4 | Hexadecimal value of the last accepted key |
| key_valid | output | 1 | One-cycle strobe marking a newly accepted key |
| press_irq | output | 1 | One-cycle interrupt when a press is seen while idle |

## Verification
A stuck or skipped scan state shows on row_out within one settle interval: a pattern out of order, held too long, or never returned to 0000. Row drive therefore exposes controller state almost immediately. A wrong column priority or a wrong lookup shows only on the key_valid strobe, one debounce interval after detection, as a wrong key_code. A broken debounce comparison shows up as a strobe appearing for a press released mid-window. A release wait that leaves too early shows up as repeated strobes or interrupts for one held key.

// File: rtl/kp_pkg.sv
package kp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCAN,
    ST_VERIFY,
    ST_RELEASE
  } scan_state_t;

  localparam int LINES = 4;

  // Key values by row (0..3), then column from high bit to low bit.
  localparam logic [63:0] KEY_MAP = 64'h1230_456F_789E_ABCD;

  function automatic logic [3:0] row_drive(input logic [1:0] idx);
    row_drive = 4'b1111 ^ (4'b1000 >> idx);
  endfunction

  function automatic logic [3:0] key_value(input logic [1:0] r, input logic [1:0] p);
    key_value = KEY_MAP[4*(15 - int'({r, p})) +: 4];
  endfunction

endpackage

// File: rtl/kp_sync.sv
module kp_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '1;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/kp_decode.sv
module kp_decode
  import kp_pkg::*;
(
  input  logic [LINES-1:0] cols,
  input  logic [1:0]       row_idx,
  output logic             hit,
  output logic [3:0]       key
);

  logic [1:0] pos;

  // Priority: the loop climbs the column bits, so the highest low bit wins.
  always_comb begin
    hit = ~&cols;
    pos = 2'd0;
    for (int b = 0; b < LINES; b++) begin
      if (!cols[b]) pos = 2'(LINES - 1 - b);
    end
    key = key_value(row_idx, pos);
  end

endmodule

// File: rtl/kp_ctrl.sv
module kp_ctrl
  import kp_pkg::*;
#(
  parameter int SETTLE_CYCLES   = 4,
  parameter int DEBOUNCE_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] col_s,
  input  logic             hit,
  input  logic [3:0]       key,
  output logic [1:0]       row_idx,
  output logic [LINES-1:0] row_out,
  output logic [3:0]       key_code,
  output logic             key_valid,
  output logic             press_irq
);

  localparam int MAXC = (SETTLE_CYCLES > DEBOUNCE_CYCLES) ? SETTLE_CYCLES : DEBOUNCE_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYCLES - 1);
  localparam logic [CW-1:0] DEB_LAST    = CW'(DEBOUNCE_CYCLES - 1);

  scan_state_t      state;
  logic [CW-1:0]    cnt;
  logic [LINES-1:0] held_cols;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      row_idx   <= 2'd0;
      cnt       <= '0;
      held_cols <= '1;
      row_out   <= '0;
      key_code  <= '0;
      key_valid <= 1'b0;
      press_irq <= 1'b0;
    end else begin
      key_valid <= 1'b0;
      press_irq <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (col_s != '1) begin
            press_irq <= 1'b1;
            state     <= ST_SCAN;
            row_idx   <= 2'd0;
            cnt       <= '0;
            row_out   <= row_drive(2'd0);
          end
        end
        ST_SCAN: begin
          if (cnt == SETTLE_LAST) begin
            cnt <= '0;
            if (hit) begin
              state     <= ST_VERIFY;
              held_cols <= col_s;
            end else if (row_idx == 2'd3) begin
              state   <= ST_RELEASE;
              row_out <= '0;
            end else begin
              row_idx <= row_idx + 2'd1;
              row_out <= row_drive(row_idx + 2'd1);
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_VERIFY: begin
          if (cnt == DEB_LAST) begin
            cnt     <= '0;
            state   <= ST_RELEASE;
            row_out <= '0;
            if (col_s == held_cols) begin
              key_valid <= 1'b1;
              key_code  <= key;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (col_s == '1) state <= ST_IDLE;
        end
      endcase
    end
  end

  // R3: rows are all low or carry exactly one low bit
  assert_row_shape_R3: assert property (@(posedge clk) disable iff (rst)
    (row_out == '0) || ($countones(row_out) == LINES - 1));

  // R3: a row pattern stays put until its settle window ends
  assert_scan_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SCAN && $past(state) == ST_SCAN && $past(cnt) != SETTLE_LAST)
      |-> $stable(row_out));

  // R2: an interrupt comes only out of the all-rows-low idle drive
  assert_irq_from_idle_R2: assert property (@(posedge clk) disable iff (rst)
    press_irq |-> ($past(row_out) == '0 && row_out != '0));

  // R6: a strobe follows only the end of a debounce window
  assert_valid_after_verify_R6: assert property (@(posedge clk) disable iff (rst)
    key_valid |-> $past(state) == ST_VERIFY);

  // R7: the strobe lasts one cycle
  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    key_valid |=> !key_valid);

  // R8: rows drop back low together with the strobe
  assert_valid_rows_low_R8: assert property (@(posedge clk) disable iff (rst)
    key_valid |-> row_out == '0);

endmodule

// File: rtl/keypad_scanner.sv
module keypad_scanner #(
  parameter int SETTLE_CYCLES   = 4,
  parameter int DEBOUNCE_CYCLES = 16,
  parameter int SYNC_STAGES     = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] col_in,
  output logic [3:0] row_out,
  output logic [3:0] key_code,
  output logic       key_valid,
  output logic       press_irq
);

  logic [3:0] col_s;
  logic [1:0] row_idx;
  logic       hit;
  logic [3:0] key;

  kp_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (col_in),
    .q   (col_s)
  );

  kp_decode u_decode (
    .cols    (col_s),
    .row_idx (row_idx),
    .hit     (hit),
    .key     (key)
  );

  kp_ctrl #(
    .SETTLE_CYCLES   (SETTLE_CYCLES),
    .DEBOUNCE_CYCLES (DEBOUNCE_CYCLES)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .col_s     (col_s),
    .hit       (hit),
    .key       (key),
    .row_idx   (row_idx),
    .row_out   (row_out),
    .key_code  (key_code),
    .key_valid (key_valid),
    .press_irq (press_irq)
  );

endmodule

// File: tb/keypad_scanner_test.sv
module keypad_scanner_test;

  localparam int SETTLE = 4;
  localparam int DEB    = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [3:0]  col_in, row_out, key_code;
  logic        key_valid, press_irq;
  logic [15:0] pressed = '0;

  keypad_scanner #(.SETTLE_CYCLES(SETTLE), .DEBOUNCE_CYCLES(DEB)) uut (
    .clk(clk), .rst(rst), .col_in(col_in), .row_out(row_out),
    .key_code(key_code), .key_valid(key_valid), .press_irq(press_irq)
  );

  // Switch matrix: key r*4+p joins row r (row_out bit 3-r) to column bit 3-p.
  always_comb begin
    col_in = 4'hF;
    for (int r = 0; r < 4; r++)
      for (int p = 0; p < 4; p++)
        if (pressed[r*4+p] && !row_out[3-r]) col_in[3-p] = 1'b0;
  end

  string KEYS = "1230456F789EABCD";
  int checks = 0, errors = 0;
  int vcount = 0, icount = 0;
  logic [3:0] vlast = '0;

  function automatic logic [3:0] hexval(byte ch);
    return (ch >= 8'h41) ? 4'(ch - 8'h37) : 4'(ch - 8'h30);
  endfunction

  function automatic logic [3:0] pat(int r);
    return ~(4'b1000 >> r);
  endfunction

  function automatic int first_low(logic [3:0] c);
    for (int p = 0; p < 4; p++) if (!c[3-p]) return p;
    return -1;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference model: phases 0 idle, 1 scanning, 2 confirming, 3 waiting for release.
  logic [3:0] q1, q2, m_held, m_rows, m_code;
  logic       m_kv, m_irq;
  int         m_phase, m_row, m_cnt;

  always @(posedge clk) begin
    logic [3:0] cs;
    int p;
    if (rst) begin
      m_phase = 0; m_row = 0; m_cnt = 0; m_held = 4'hF;
      m_rows = 4'h0; m_code = 4'h0; m_kv = 1'b0; m_irq = 1'b0;
      q1 = 4'hF; q2 = 4'hF;
    end else begin
      cs = q2;
      m_kv = 1'b0;
      m_irq = 1'b0;
      case (m_phase)
        0: if (cs != 4'hF) begin
             m_irq = 1'b1; m_phase = 1; m_row = 0; m_cnt = 0; m_rows = pat(0);
           end
        1: if (m_cnt == SETTLE - 1) begin
             m_cnt = 0;
             p = first_low(cs);
             if (p >= 0) begin m_phase = 2; m_held = cs; end
             else if (m_row == 3) begin m_phase = 3; m_rows = 4'h0; end
             else begin m_row++; m_rows = pat(m_row); end
           end else m_cnt++;
        2: if (m_cnt == DEB - 1) begin
             m_cnt = 0; m_phase = 3; m_rows = 4'h0;
             if (cs == m_held) begin
               m_kv = 1'b1;
               m_code = hexval(KEYS[m_row*4 + first_low(cs)]);
             end
           end else m_cnt++;
        default: if (cs == 4'hF) m_phase = 0;
      endcase
      q2 = q1;
      q1 = col_in;
    end
  end

  // Compare against the model on every cycle, away from the active edge.
  always @(negedge clk) begin
    check(row_out === m_rows,   "R3 row drive vs model", row_out, m_rows);
    check(key_valid === m_kv,   "R7 key_valid vs model", key_valid, m_kv);
    check(key_code === m_code,  "R4 key_code vs model", key_code, m_code);
    check(press_irq === m_irq,  "R2 press_irq vs model", press_irq, m_irq);
    if (key_valid) begin vcount++; vlast = key_code; end
    if (press_irq) icount++;
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int v0, i0;
    cycles(3);
    check(row_out == 4'h0,  "R1 reset rows", row_out, 0);
    check(key_valid == 1'b0, "R1 reset key_valid", key_valid, 0);
    check(press_irq == 1'b0, "R1 reset press_irq", press_irq, 0);
    check(key_code == 4'h0,  "R1 reset key_code", key_code, 0);
    rst = 1'b0;
    cycles(1);
    check(row_out == 4'h0, "R1 rows after reset release", row_out, 0);
    cycles(5);

    // Every key alone: R4 mapping, R2 one interrupt, R7 one strobe.
    for (int k = 0; k < 16; k++) begin
      v0 = vcount; i0 = icount;
      pressed = 16'(1) << k;
      cycles(80);
      pressed = '0;
      cycles(12);
      check(vcount == v0 + 1, "R7 one strobe per press", vcount - v0, 1);
      check(vlast == hexval(KEYS[k]), "R4 key value", vlast, hexval(KEYS[k]));
      check(icount == i0 + 1, "R2 one interrupt per press", icount - i0, 1);
    end

    // R5: keys 5 and F share a row; the higher column bit (5) wins.
    v0 = vcount;
    pressed = (16'(1) << 5) | (16'(1) << 7);
    cycles(80); pressed = '0; cycles(12);
    check(vcount == v0 + 1, "R5 single report", vcount - v0, 1);
    check(vlast == 4'h5, "R5 column priority", vlast, 5);

    // R5/R3: keys 2 and 9 in different rows; the earlier row (2) wins.
    v0 = vcount;
    pressed = (16'(1) << 1) | (16'(1) << 10);
    cycles(80); pressed = '0; cycles(12);
    check(vlast == 4'h2, "R5 scan order precedence", vlast, 2);

    // R6: key released inside the debounce window gives no strobe.
    v0 = vcount;
    pressed = 16'(1) << 0;
    cycles(12); pressed = '0; cycles(40);
    check(vcount == v0, "R6 bounce rejected", vcount - v0, 0);
    check(row_out == 4'h0, "R6 rows idle after reject", row_out, 0);

    // R8: a key held long is reported once and interrupts once.
    v0 = vcount; i0 = icount;
    pressed = 16'(1) << 6;
    cycles(300);
    check(vcount == v0 + 1, "R8 held key reported once", vcount - v0, 1);
    check(icount == i0 + 1, "R8 no rescan while held", icount - i0, 1);
    check(row_out == 4'h0, "R8 rows low while held", row_out, 0);
    pressed = '0; cycles(12);

    // R9: key D let go before its row is reached.
    v0 = vcount; i0 = icount;
    pressed = 16'(1) << 15;
    cycles(3); pressed = '0; cycles(40);
    check(icount == i0 + 1, "R9 press seen", icount - i0, 1);
    check(vcount == v0, "R9 vanished key not reported", vcount - v0, 0);
    check(row_out == 4'h0, "R9 rows back low", row_out, 0);
    check(key_code == 4'h6, "R7 key_code held", key_code, 6);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R7 actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule